// File: doc/BRIEF.md
# One-Time-Programmable Region Lock Controller

This block holds a 1024-byte one-time-programmable area in a register array and checks every byte-wide program request against a set of protection rules. A program request can only clear bits. The stored byte becomes the AND of the old byte and the new byte, so a 0 can never return to 1. The first 16 bytes hold a factory-written identifier that no request can alter.

The area is divided into 32 regions. Each region is 32 bytes long and starts on a 32-byte boundary. Four lock bytes held inside region 0 provide one guard bit per region, and a region whose guard bit is 0 refuses programming. A global freeze input blocks all programming, whatever the guard bits say. When a program request is refused, the data stays unchanged and a reject flag is raised for one cycle. Reads are always served.

Because the lock bytes sit in region 0, clearing the guard bit of region 0 also seals the lock bytes themselves and the reserved bytes next to them.

Top module: `otp_lock_guard`

## Requirements
- R1: After reset, byte i for i in 0..15 reads ((i*59) mod 256) XOR 0xA5, and every byte from 0x010 to 0x3FF reads 0xFF.
- R2: A read request with rd_valid high at a clock edge presents the byte at rd_addr on rd_data from that edge until the next read edge, where it is replaced by the next read. Reads are served in every state, including while frozen. A read in the same cycle as a program of the same byte returns the old value.
- R3: An accepted program request stores (old AND prog_data), so a bit can change only from 1 to 0.
- R4: A program request to any byte from 0x000 to 0x00F is rejected and leaves the byte unchanged.
- R5: Region r covers bytes 32r..32r+31. Region r is locked when bit (r mod 8) of byte 0x010 + (r div 8) is 0. A program request to a locked region is rejected and leaves the data unchanged.
- R6: While freeze_n is 0, every program request is rejected.
- R7: prog_reject is high for exactly the cycle after the edge of each rejected request. It stays low after accepted requests and after idle cycles.
- R8: Reserved bytes 0x014 to 0x01F accept programming while region 0 is unlocked.
- R9: Once the guard bit of region 0 (bit 0 of byte 0x010) is cleared, the lock bytes and reserved bytes reject programming.
- R10: A guard bit cleared by a request at one edge already governs a request at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, restores the delivered contents |
| freeze_n | input | 1 | 0 blocks all programming |
| prog_valid | input | 1 | Program request strobe |
| prog_addr | input | 10 | Byte address of the program request |
| prog_data | input | 8 | Byte to AND into the addressed location |
| rd_valid | input | 1 | Read request strobe |
| rd_addr | input | 10 | Byte address of the read request |
| rd_data | output | 8 | Read data, one cycle after the request |
| prog_reject | output | 1 | One-cycle pulse for a refused program request |

## Verification
Program requests are directed at several classes of byte: the factory bytes, the reserved bytes, ordinary bytes in unlocked regions, regions just locked, and the two ends of the region range (region 30 next to region 31). Together these patterns separate the address rule, the guard-bit rule and the freeze rule from one another. Repeated programs of one byte with overlapping patterns, including an all-ones pattern, separate AND semantics from plain overwrite. Back-to-back requests, a lock followed by a program in the very next cycle, and reads issued while frozen expose any off-by-one cycle in lock decoding or in read timing.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;
   // Delivered content of the factory identifier bytes.
   function automatic logic [7:0] factory_byte(input int idx, input logic [7:0] seed);
      int v;
      v = (idx * 59) % 256;
      return v[7:0] ^ seed;
   endfunction
endpackage

// File: rtl/otp_store.sv
module otp_store #(
   parameter int BYTES         = 1024,
   parameter int FACTORY_BYTES = 16,
   parameter int LOCK_BASE     = 16,
   parameter int NREG          = 32,
   parameter logic [7:0] SEED  = 8'hA5,
   localparam int AW           = $clog2(BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [7:0]      wr_data,
   input  logic            rd_en,
   input  logic [AW-1:0]   rd_addr,
   output logic [7:0]      rd_data,
   output logic [NREG-1:0] lock_vec
);
   logic [7:0] mem [BYTES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < BYTES; i++)
            mem[i] <= (i < FACTORY_BYTES) ? otp_lock_pkg::factory_byte(i, SEED) : 8'hFF;
         rd_data <= 8'h00;
      end else begin
         if (wr_en)
            mem[wr_addr] <= mem[wr_addr] & wr_data;
         if (rd_en)
            rd_data <= mem[rd_addr];
      end
   end

   // One guard bit per region, taken from the lock bytes.
   for (genvar g = 0; g < NREG; g++) begin : g_lock
      assign lock_vec[g] = mem[LOCK_BASE + g / 8][g % 8];
   end
endmodule

// File: rtl/otp_lock_decode.sv
module otp_lock_decode #(
   parameter int BYTES         = 1024,
   parameter int REG_BYTES     = 32,
   parameter int FACTORY_BYTES = 16,
   localparam int AW           = $clog2(BYTES),
   localparam int RW           = $clog2(REG_BYTES),
   localparam int NREG         = BYTES / REG_BYTES
) (
   input  logic [AW-1:0]   addr,
   input  logic            freeze_n,
   input  logic [NREG-1:0] lock_vec,
   output logic            allow
);
   logic [AW-RW-1:0] region;
   logic             factory_hit;

   assign region      = addr[AW-1:RW];
   assign factory_hit = int'(addr) < FACTORY_BYTES;
   assign allow       = freeze_n & ~factory_hit & lock_vec[region];
endmodule

// File: rtl/otp_lock_guard.sv
module otp_lock_guard #(
   parameter int BYTES         = 1024,
   parameter int REG_BYTES     = 32,
   parameter int FACTORY_BYTES = 16,
   parameter int LOCK_BASE     = 16,
   parameter logic [7:0] SEED  = 8'hA5,
   localparam int AW           = $clog2(BYTES),
   localparam int NREG         = BYTES / REG_BYTES,
   localparam int LOCK_BYTES   = NREG / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          freeze_n,
   input  logic          prog_valid,
   input  logic [AW-1:0] prog_addr,
   input  logic [7:0]    prog_data,
   input  logic          rd_valid,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic          prog_reject
);
   if ((1 << AW) != BYTES) begin : g_chk_bytes
      $error("BYTES must be a power of two");
   end
   if ((1 << $clog2(REG_BYTES)) != REG_BYTES || REG_BYTES > BYTES) begin : g_chk_reg
      $error("REG_BYTES must be a power of two not above BYTES");
   end
   if (NREG % 8 != 0) begin : g_chk_nreg
      $error("region count must be a multiple of eight");
   end
   if (LOCK_BASE < FACTORY_BYTES || LOCK_BASE + LOCK_BYTES > REG_BYTES) begin : g_chk_lock
      $error("lock bytes must follow the factory bytes inside region 0");
   end

   logic [NREG-1:0] lock_vec;
   logic            allow;
   logic            accept;

   otp_lock_decode #(
      .BYTES(BYTES), .REG_BYTES(REG_BYTES), .FACTORY_BYTES(FACTORY_BYTES)
   ) u_dec (
      .addr(prog_addr), .freeze_n(freeze_n), .lock_vec(lock_vec), .allow(allow)
   );

   assign accept = prog_valid & allow;

   otp_store #(
      .BYTES(BYTES), .FACTORY_BYTES(FACTORY_BYTES), .LOCK_BASE(LOCK_BASE),
      .NREG(NREG), .SEED(SEED)
   ) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_en(accept), .wr_addr(prog_addr), .wr_data(prog_data),
      .rd_en(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
      .lock_vec(lock_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) prog_reject <= 1'b0;
      else        prog_reject <= prog_valid & ~allow;
   end
endmodule

// File: rtl/otp_lock_guard_chk.sv
module otp_lock_guard_chk #(
   parameter int AW            = 10,
   parameter int FACTORY_BYTES = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          freeze_n,
   input logic          prog_valid,
   input logic [AW-1:0] prog_addr,
   input logic          rd_valid,
   input logic [AW-1:0] rd_addr,
   input logic [7:0]    rd_data,
   input logic          prog_reject
);
   // R7: a reject pulse only follows a program request
   p_reject_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      prog_reject |-> $past(prog_valid));

   // R6: frozen requests are refused
   p_frozen_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_valid && !freeze_n) |=> prog_reject);

   // R4: factory bytes are refused
   p_factory_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_valid && int'(prog_addr) < FACTORY_BYTES) |=> prog_reject);

   // R2: read data holds when no read is requested
   p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> $stable(rd_data));

   // R3: two successive reads of one byte never show a bit rising
   p_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_valid) && rd_addr == $past(rd_addr))
      |=> ((rd_data & ~$past(rd_data)) == 8'h00));
endmodule

bind otp_lock_guard otp_lock_guard_chk #(.AW(AW), .FACTORY_BYTES(FACTORY_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .freeze_n(freeze_n), .prog_valid(prog_valid),
   .prog_addr(prog_addr), .rd_valid(rd_valid), .rd_addr(rd_addr),
   .rd_data(rd_data), .prog_reject(prog_reject)
);

// File: tb/sim_otp_lock_guard.sv
`timescale 1ns/1ps
module sim_otp_lock_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       freeze_n = 1'b1;
   logic       prog_valid = 1'b0;
   logic [9:0] prog_addr = '0;
   logic [7:0] prog_data = '0;
   logic       rd_valid = 1'b0;
   logic [9:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       prog_reject;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   otp_lock_guard u0 (
      .clk(clk), .rst_n(rst_n), .freeze_n(freeze_n), .prog_valid(prog_valid),
      .prog_addr(prog_addr), .prog_data(prog_data), .rd_valid(rd_valid),
      .rd_addr(rd_addr), .rd_data(rd_data), .prog_reject(prog_reject)
   );

   // Reference contents, built from the requirements.
   logic [7:0] mdl [1024];
   logic [7:0] q_rd [$];
   string      q_rt [$];
   bit         q_pj [$];
   string      q_pt [$];
   bit         pend_rd = 1'b0;
   bit         pend_pg = 1'b0;

   function automatic logic [7:0] fact(input int i);
      int v;
      v = ((i * 59) % 256) ^ 8'hA5;
      return v[7:0];
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, input string tag);
      @(posedge clk); #2;
      prog_valid = 1'b0;
      rd_valid = 1'b1;
      rd_addr = a[9:0];
      q_rd.push_back(mdl[a]);
      q_rt.push_back(tag);
   endtask

   task automatic pg(input int a, input logic [7:0] d, input string tag);
      bit rej;
      int r;
      @(posedge clk); #2;
      rd_valid = 1'b0;
      prog_valid = 1'b1;
      prog_addr = a[9:0];
      prog_data = d;
      r = a / 32;
      rej = (a < 16) || !freeze_n || (mdl[16 + r / 8][r % 8] == 1'b0);
      if (!rej) mdl[a] = mdl[a] & d;
      q_pj.push_back(rej);
      q_pt.push_back(tag);
   endtask

   task automatic idle();
      @(posedge clk); #2;
      prog_valid = 1'b0;
      rd_valid = 1'b0;
   endtask

   always @(posedge clk) begin
      pend_rd <= rst_n && rd_valid;
      pend_pg <= rst_n && prog_valid;
   end

   // Monitor: compare against the scoreboard away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (pend_rd && q_rd.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_rd.pop_front();
            t = q_rt.pop_front();
            check(t, rd_data, e);
         end
         if (pend_pg && q_pj.size() > 0) begin
            bit e;
            string t;
            e = q_pj.pop_front();
            t = q_pt.pop_front();
            check({t, " reject R7"}, prog_reject, e);
         end else if (!pend_pg) begin
            check("R7 idle no reject", prog_reject, 0);
         end
      end
   end

   initial begin
      for (int i = 0; i < 1024; i++) mdl[i] = (i < 16) ? fact(i) : 8'hFF;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 delivered state
      for (int i = 0; i < 16; i++) rd(i, "R1 factory byte");
      rd(16, "R1 lock byte");
      rd(19, "R1 lock byte");
      rd(20, "R1 reserved");
      rd(1023, "R1 top byte");

      // R3 AND semantics
      pg(64, 8'hF0, "R3 first");
      pg(64, 8'h3C, "R3 second");
      pg(64, 8'hFF, "R3 all ones");
      rd(64, "R3 result");
      rd(64, "R3 reread");

      // R4 factory bytes
      pg(5, 8'h00, "R4 factory");
      pg(15, 8'h00, "R4 factory top");
      rd(5, "R4 unchanged");
      rd(15, "R4 unchanged");

      // R8 reserved bytes
      pg(21, 8'h12, "R8 reserved");
      pg(31, 8'h81, "R8 reserved end");
      rd(21, "R8 readback");
      rd(31, "R8 readback");

      // R5 and R10: lock region 2, then program it at once
      pg(16, 8'hFB, "R5 lock region 2");
      pg(69, 8'h00, "R10 next cycle");
      rd(69, "R5 unchanged");
      pg(96, 8'h00, "R5 region 3 open");
      rd(96, "R5 region 3 value");
      rd(16, "R5 lock byte value");

      // R5 region 31 edge
      pg(19, 8'h7F, "R5 lock region 31");
      pg(1023, 8'h00, "R5 region 31 top");
      pg(992, 8'h00, "R5 region 31 base");
      pg(991, 8'h0F, "R5 region 30 open");
      rd(1023, "R5 region 31 unchanged");
      rd(991, "R5 region 30 value");

      // R2 same-cycle read returns old value
      @(posedge clk); #2;
      prog_valid = 1'b1; prog_addr = 10'd200; prog_data = 8'h00;
      rd_valid = 1'b1; rd_addr = 10'd200;
      q_pj.push_back(1'b0); q_pt.push_back("R2 same cycle prog");
      q_rd.push_back(mdl[200]); q_rt.push_back("R2 same cycle old value");
      mdl[200] = 8'h00;
      rd(200, "R2 new value");

      // R9 seal region 0
      pg(16, 8'hFE, "R9 lock region 0");
      pg(17, 8'h00, "R9 lock byte sealed");
      pg(24, 8'h00, "R9 reserved sealed");
      pg(16, 8'h00, "R9 own lock byte sealed");
      rd(16, "R9 lock byte value");
      rd(24, "R9 reserved unchanged");

      // R6 freeze
      @(posedge clk); #2; freeze_n = 1'b0; prog_valid = 1'b0; rd_valid = 1'b0;
      pg(128, 8'h00, "R6 frozen");
      pg(1000, 8'h00, "R6 frozen other");
      rd(128, "R6 R2 read while frozen");
      @(posedge clk); #2; freeze_n = 1'b1; prog_valid = 1'b0; rd_valid = 1'b0;
      pg(128, 8'h55, "R6 thawed");
      rd(128, "R6 thawed value");

      idle();
      idle();
      idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule